// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block is the arithmetic core for a pair of 8-bit accumulators, called A and B. It adds and subtracts byte operands into either accumulator. It also combines the two accumulators with each other, and it can chain a carry or a borrow in from a previous step. For word arithmetic the pair is read as one 16-bit value, with A in the upper half and B in the lower half.

Each accepted operation updates the accumulators and five status bits: carry/borrow, signed overflow, zero, negative and half-carry. The half-carry bit is used for decimal work, so only the byte-add family writes it.

A sequencer presents an operation code, an operand, a carry input and a write strobe. The result registers on the next rising clock edge while the strobe is high. The accumulators and status bits are outputs and can be read at all times.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high reset clears A, B and all five status bits to 0 on the next rising edge.
- R2: When `wr_en` is low at a rising edge, A, B and every status bit keep their values.
- R3: Operation code 1 writes A+B into A and leaves B unchanged. C is the carry out of bit 7, and H is the carry out of bit 3.
- R4: Operation code 2 writes A-B into A and leaves B unchanged. C is set when a borrow occurs (B greater than A as unsigned), and H is unchanged.
- R5: Operation codes 3 (add) and 4 (add plus `carry_in`) add `operand[7:0]` into A when `dst_b`=0, or into B when `dst_b`=1, and leave the other accumulator unchanged. C is the carry out of bit 7, and H is the carry out of bit 3 including `carry_in`.
- R6: Operation codes 5 (subtract) and 6 (subtract `operand[7:0]` and `carry_in`) write into the accumulator that `dst_b` selects. C is set when a borrow occurs, and H is unchanged.
- R7: Operation codes 7 and 8 add or subtract the 16-bit `operand` to or from D={A,B}. The operand's upper byte is in `operand[15:8]`. A receives result bits 15:8 and B receives bits 7:0. C is the carry or borrow out of bit 15, Z and N are taken over all 16 bits, and H is unchanged.
- R8: V is set exactly when the signed result overflows. For an add, the operands have the same sign and the result's sign differs from it. For a subtract, the operands' signs differ and the result's sign differs from the minuend's sign.
- R9: Z is set when the result is zero, and N equals the result's most significant bit. Operation code 0 and codes 9 to 15 change nothing, even with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe; the operation takes effect only while high |
| op_code | input | 4 | Operation select (0 none, 1 A+B, 2 A-B, 3 add, 4 add with carry, 5 sub, 6 sub with borrow, 7 word add, 8 word sub) |
| dst_b | input | 1 | Byte operations 3 to 6: 0 targets A, 1 targets B |
| operand | input | 16 | Operand; bits 7:0 for byte operations, all 16 bits for word operations |
| carry_in | input | 1 | Carry or borrow chained in by codes 4 and 6 |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| acc_d | output | 16 | Word view {A,B} |
| flag_h | output | 1 | Half-carry |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry / borrow |

## Verification
Every result in this block lands exactly one rising edge after the stimulus: the accumulators and all five status bits pass through one register stage each, and no output is combinational from the inputs. The bench drives inputs on a falling edge and lets one rising edge pass. It then compares the registered outputs with its own model on the following falling edge, which is also when it drives the next operation, so each stimulus is applied exactly once. Cases where the strobe is low, and unused operation codes, are checked in the same cycle position to show that nothing moved.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 4'd0,
        OP_ABA  = 4'd1,
        OP_SBA  = 4'd2,
        OP_ADD  = 4'd3,
        OP_ADC  = 4'd4,
        OP_SUB  = 4'd5,
        OP_SBC  = 4'd6,
        OP_ADDW = 4'd7,
        OP_SUBW = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic act;      // operation writes state
        logic word;     // 16-bit operation on {A,B}
        logic sub;      // subtract instead of add
        logic use_cin;  // chain carry_in
        logic pair;     // A op B into A
        logic upd_h;    // half-carry is written
    } alu_ctl_t;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } alu_flags_t;

    function automatic alu_ctl_t decode_op(input logic [OP_W-1:0] code);
        alu_ctl_t k;
        k = '0;
        case (code)
            OP_ABA:  begin k.act = 1'b1; k.pair = 1'b1; k.upd_h = 1'b1; end
            OP_SBA:  begin k.act = 1'b1; k.pair = 1'b1; k.sub = 1'b1; end
            OP_ADD:  begin k.act = 1'b1; k.upd_h = 1'b1; end
            OP_ADC:  begin k.act = 1'b1; k.upd_h = 1'b1; k.use_cin = 1'b1; end
            OP_SUB:  begin k.act = 1'b1; k.sub = 1'b1; end
            OP_SBC:  begin k.act = 1'b1; k.sub = 1'b1; k.use_cin = 1'b1; end
            OP_ADDW: begin k.act = 1'b1; k.word = 1'b1; end
            OP_SUBW: begin k.act = 1'b1; k.word = 1'b1; k.sub = 1'b1; end
            default: k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/aau_decode.sv
module aau_decode
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output alu_ctl_t        ctl
);
    always_comb begin
        ctl = decode_op(op_code);
    end
endmodule

// File: rtl/aau_adder.sv
module aau_adder #(
    parameter int W    = 8,
    parameter int HALF = W / 2
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_flag,
    output logic         v_flag,
    output logic         h_flag
);
    logic [W-1:0]  ye;
    logic          ce;
    logic [W:0]    full;
    logic [HALF:0] low;

    // subtraction as x + ~y + ~borrow; the carry out is the inverted borrow
    assign ye   = sub ? ~y : y;
    assign ce   = sub ? ~cin : cin;
    assign full = {1'b0, x} + {1'b0, ye} + {{W{1'b0}}, ce};
    assign low  = {1'b0, x[HALF-1:0]} + {1'b0, ye[HALF-1:0]} + {{HALF{1'b0}}, ce};

    assign sum    = full[W-1:0];
    assign c_flag = sub ? ~full[W] : full[W];
    assign v_flag = (x[W-1] == ye[W-1]) && (full[W-1] != x[W-1]);
    assign h_flag = low[HALF];
endmodule

// File: rtl/aau_state.sv
module aau_state
    import acc_alu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              word,
    input  logic              to_b,
    input  logic [BYTE_W-1:0] byte_res,
    input  logic [2*BYTE_W-1:0] word_res,
    input  alu_flags_t        flags_nxt,
    output logic [BYTE_W-1:0] a_q,
    output logic [BYTE_W-1:0] b_q,
    output alu_flags_t        flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            b_q     <= '0;
            flags_q <= '0;
        end else if (we) begin
            flags_q <= flags_nxt;
            if (word) begin
                a_q <= word_res[2*BYTE_W-1:BYTE_W];
                b_q <= word_res[BYTE_W-1:0];
            end else if (to_b) begin
                b_q <= byte_res;
            end else begin
                a_q <= byte_res;
            end
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [OP_W-1:0]      op_code,
    input  logic                 dst_b,
    input  logic [2*BYTE_W-1:0]  operand,
    input  logic                 carry_in,
    output logic [BYTE_W-1:0]    acc_a,
    output logic [BYTE_W-1:0]    acc_b,
    output logic [2*BYTE_W-1:0]  acc_d,
    output logic                 flag_h,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_v,
    output logic                 flag_c
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int HALF_W = BYTE_W / 2;

    alu_ctl_t            ctl;
    alu_flags_t          flags_q, flags_nxt;
    logic [BYTE_W-1:0]   a_q, b_q, tgt, src;
    logic                to_b, cin_eff;
    logic [BYTE_W-1:0]   byte_res;
    logic [WORD_W-1:0]   word_res;
    logic                bc, bv, bh, wc, wv, wh;

    aau_decode u_dec (.op_code(op_code), .ctl(ctl));

    assign to_b    = dst_b & ~ctl.pair;
    assign tgt     = to_b ? b_q : a_q;
    assign src     = ctl.pair ? b_q : operand[BYTE_W-1:0];
    assign cin_eff = ctl.use_cin & carry_in;

    aau_adder #(.W(BYTE_W), .HALF(HALF_W)) u_byte (
        .x(tgt), .y(src), .sub(ctl.sub), .cin(cin_eff),
        .sum(byte_res), .c_flag(bc), .v_flag(bv), .h_flag(bh)
    );

    aau_adder #(.W(WORD_W), .HALF(HALF_W)) u_word (
        .x({a_q, b_q}), .y(operand), .sub(ctl.sub), .cin(1'b0),
        .sum(word_res), .c_flag(wc), .v_flag(wv), .h_flag(wh)
    );

    always_comb begin
        if (ctl.word) begin
            flags_nxt.c = wc;
            flags_nxt.v = wv;
            flags_nxt.z = (word_res == '0);
            flags_nxt.n = word_res[WORD_W-1];
        end else begin
            flags_nxt.c = bc;
            flags_nxt.v = bv;
            flags_nxt.z = (byte_res == '0);
            flags_nxt.n = byte_res[BYTE_W-1];
        end
        flags_nxt.h = ctl.upd_h ? (ctl.word ? wh : bh) : flags_q.h;
    end

    aau_state #(.BYTE_W(BYTE_W)) u_state (
        .clk(clk), .rst(rst), .we(wr_en & ctl.act), .word(ctl.word),
        .to_b(to_b), .byte_res(byte_res), .word_res(word_res),
        .flags_nxt(flags_nxt), .a_q(a_q), .b_q(b_q), .flags_q(flags_q)
    );

    assign acc_a  = a_q;
    assign acc_b  = b_q;
    assign acc_d  = {a_q, b_q};
    assign flag_h = flags_q.h;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_d == '0) && !flag_h && !flag_n && !flag_z && !flag_v && !flag_c);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(acc_d) && $stable({flag_h, flag_n, flag_z, flag_v, flag_c}));

    // R4
    pair_keeps_b_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && (op_code == OP_ABA || op_code == OP_SBA) |=> $stable(acc_b));

    // R6
    sub_keeps_h_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && (op_code == OP_SUB || op_code == OP_SBC || op_code == OP_SBA) |=> $stable(flag_h));

    // R7
    word_nz_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && (op_code == OP_ADDW || op_code == OP_SUBW)
        |=> (flag_n == acc_a[BYTE_W-1]) && (flag_z == (acc_d == '0)) && $stable(flag_h));

    // R9
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && (op_code == OP_NONE || op_code > OP_SUBW) |=> $stable(acc_d) && $stable(flag_c));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        dst_b = 1'b0;
    logic [15:0] operand = 16'h0;
    logic        carry_in = 1'b0;
    logic [7:0]  acc_a, acc_b;
    logic [15:0] acc_d;
    logic        flag_h, flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int errors = 0;
    logic [7:0] ma, mb;
    logic [4:0] mf; // {h,n,z,v,c}

    always #5 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .op_code(op_code), .dst_b(dst_b),
        .operand(operand), .carry_in(carry_in), .acc_a(acc_a), .acc_b(acc_b),
        .acc_d(acc_d), .flag_h(flag_h), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic string tag_of(input logic we, input logic [3:0] op);
        if (!we) return "R2";
        case (op)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd4: return "R5";
            4'd5, 4'd6: return "R6";
            4'd7, 4'd8: return "R7";
            default: return "R9";
        endcase
    endfunction

    // reference model of one operation, written from the requirements
    task automatic model(input logic we, input logic [3:0] op, input logic db,
                         input logic [15:0] opd, input logic ci);
        int x, y, c, r;
        logic [7:0] rb;
        logic [15:0] rw;
        logic h, sub, wordop, tob;
        if (!we || op == 0 || op > 8) return;
        sub    = (op == 2 || op == 5 || op == 6 || op == 8);
        wordop = (op == 7 || op == 8);
        h      = mf[4];
        if (wordop) begin
            x = {ma, mb}; y = opd;
            r = sub ? x - y : x + y;
            rw = r[15:0];
            mf[0] = sub ? (r < 0) : (r > 16'hFFFF);
            mf[1] = sub ? (x[15] != y[15] && rw[15] != x[15]) : (x[15] == y[15] && rw[15] != x[15]);
            mf[2] = (rw == 16'h0);
            mf[3] = rw[15];
            ma = rw[15:8]; mb = rw[7:0];
        end else begin
            tob = (op >= 3) && db;
            x = tob ? mb : ma;
            y = (op <= 2) ? mb : opd[7:0];
            c = (op == 4 || op == 6) ? ci : 0;
            r = sub ? x - y - c : x + y + c;
            rb = r[7:0];
            mf[0] = sub ? (r < 0) : (r > 255);
            mf[1] = sub ? (x[7] != y[7] && rb[7] != x[7]) : (x[7] == y[7] && rb[7] != x[7]);
            mf[2] = (rb == 8'h0);
            mf[3] = rb[7];
            if (!sub) h = ((x & 15) + (y & 15) + c) > 15;
            if (tob) mb = rb; else ma = rb;
        end
        mf[4] = h;
    endtask

    task automatic compare(input string tag);
        chk(tag, "A", {8'h0, acc_a}, {8'h0, ma});
        chk(tag, "B", {8'h0, acc_b}, {8'h0, mb});
        chk(tag, "D", acc_d, {ma, mb});
        chk(tag, "flags hnzvc", {11'h0, flag_h, flag_n, flag_z, flag_v, flag_c}, {11'h0, mf});
    endtask

    // drive at a falling edge, one rising edge applies it, check at the next falling edge
    task automatic step(input string tag, input logic we, input logic [3:0] op,
                        input logic db, input logic [15:0] opd, input logic ci);
        wr_en = we; op_code = op; dst_b = db; operand = opd; carry_in = ci;
        model(we, op, db, opd, ci);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        ma = 0; mb = 0; mf = 0;
        compare("R1");
        rst = 1'b0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        ma = 0; mb = 0; mf = 0;
        seed = $urandom(32'h5EED_0042);
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // R5 signed overflow into the sign bit, half-carry set
        step("R5", 1, 4'd3, 0, 16'h007F, 0);
        step("R8", 1, 4'd3, 0, 16'h0001, 0);
        // R5 carry out and zero result, into B
        step("R5", 1, 4'd3, 1, 16'h00FF, 0);
        step("R5", 1, 4'd3, 1, 16'h0001, 0);
        step("R5", 1, 4'd4, 1, 16'h000E, 1);
        // R6 borrow from B, sub with borrow, H kept
        step("R6", 1, 4'd5, 1, 16'h0020, 0);
        step("R6", 1, 4'd6, 0, 16'h0080, 1);
        step("R8", 1, 4'd5, 0, 16'h0001, 0);
        // R3 / R4 accumulator pair
        step("R3", 1, 4'd1, 1, 16'hFFFF, 1);
        step("R4", 1, 4'd2, 1, 16'hFFFF, 1);
        step("R4", 1, 4'd2, 0, 16'h0000, 0);
        // R7 word add wraps to zero, word subtract borrows
        step("R7", 1, 4'd8, 0, {ma, mb}, 0);
        step("R7", 1, 4'd8, 0, 16'h0001, 0);
        step("R7", 1, 4'd7, 0, 16'h0001, 0);
        step("R7", 1, 4'd7, 0, 16'h8000, 0);
        step("R8", 1, 4'd7, 0, 16'h8000, 0);
        // R2 strobe low, R9 unused codes
        step("R2", 0, 4'd3, 0, 16'h0055, 1);
        step("R9", 1, 4'd0, 0, 16'h0055, 1);
        step("R9", 1, 4'd12, 1, 16'h1234, 1);

        for (int i = 0; i < 400; i++) begin
            logic we;
            logic [3:0] op;
            we = ($urandom % 8) != 0;
            op = $urandom % 16;
            if (op > 8 && ($urandom % 2)) op = op - 8;
            step(tag_of(we, op), we, op, $urandom % 2, $urandom, $urandom % 2);
        end

        step("R5", 1, 4'd3, 0, 16'h0033, 0);
        do_reset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule